// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a 52-bit physical address by reading one 64-bit table entry per level through a single memory port. It starts from a root table frame and descends four levels. The walk ends early with a fault when an entry is absent or when the permissions gathered so far forbid the access.

A request carries the virtual address, an access kind and a flag that marks a user-mode access. Each visited entry gets its accessed flag set. On a write access, the last-level entry also gets its dirty flag set. An entry is written back in place only when one of those flags actually changes. That write is issued before the read for the next level. Exactly one walk is in progress at a time. The result comes back with a single-cycle completion pulse.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `done` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: Level n (1 to 4) reads the 64-bit entry at address {table frame, index n, 3'b000}. The level-1 table frame is `root_frame`. Each later table frame is bits 51:12 of the entry just read. The index for level 1 is VA bits 47:39, level 2 uses 38:30, level 3 uses 29:21 and level 4 uses 20:12.
- R3: A walk that completes without a fault pulses `done` high for exactly one cycle with `fault` = 2'b00. At the same time `paddr` = {level-4 entry bits 51:12, VA bits 11:0}.
- R4: An entry whose bit 0 (present) is 0 ends the walk with `fault` = 2'b01 and `paddr` = 0. No further read is issued, and that entry is not written.
- R5: Every entry that is traversed without a fault gets bit 5 (accessed) set. It is written back to its own address before the next read. It is written back only when its value changes.
- R6: Bit 6 (dirty) is set only in the level-4 entry and only on a write access (`req_access` = 2'b01). For reads (2'b00, and 2'b11) and fetches (2'b10), bit 6 is written back unchanged.
- R7: A write access ends with `fault` = 2'b10 when bit 1 (read/write) is 0 in any entry reached so far.
- R8: A fault of 2'b11 ends the walk in two cases: a user access (`req_user` = 1) where bit 2 (user) is 0 in any entry reached so far, or a fetch where bit 63 (no-execute) is 1 in any entry reached so far. When both this fault and the R7 condition hold, 2'b11 wins. Bit 2 has no effect on supervisor accesses, and bit 63 has no effect on reads and writes.
- R9: The entry on which a protection fault (R7, R8) is detected is not written. Entries at earlier levels keep their writebacks.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, write flag and write data hold steady. `req_ready` is low for the whole walk.
- R11: Entry bits 3, 4 and 7, and bit 6 of entries at levels 1 to 3, do not change the result. They are carried into writebacks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 48 | Virtual address to translate |
| req_access | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_user | input | 1 | 1 for a user-mode access |
| root_frame | input | 40 | Frame number of the level-1 table |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_we | output | 1 | 1 for an entry writeback |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 00 none, 01 absent, 10 write denied, 11 user or fetch denied |
| paddr | output | 52 | Translated physical address |

## Verification
The main function is exercised with several kinds of walk:
- **Fully permitted chains with clear flags.** These separate correct index slicing and frame chaining from swapped levels, because every read and write address is compared in order.
- **The same address walked again, then written.** This tells a writeback that depends on a change apart from one that always fires. It also shows that the dirty flag lands only on the leaf.
- **Chains with one deny bit placed at different levels.** These show whether permissions accumulate across levels, which code wins when two denials coincide, and that the faulting entry is left alone.
- **Entries carrying cache-policy and size bits, and supervisor or read accesses with the user and no-execute bits set.** These show that those bits are ignored.
- **Varied memory ready patterns and read latencies.** These exercise the handshake.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 64-bit table entries with fixed flag positions.
package ptw_pkg;

    // Flag positions inside a table entry
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACCESS  = 5;
    localparam int BIT_DIRTY   = 6;
    localparam int BIT_NOEXEC  = 63;

    // Access kinds
    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ABSENT  = 2'b01,
        FLT_WRPROT  = 2'b10,
        FLT_UXPROT  = 2'b11
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_EVAL,
        ST_WB_REQ
    } walk_state_e;

endpackage

// File: rtl/ptw_index_sel.sv
// Selects the table index for the current level out of the virtual page number.
// Assumes level 0 uses the most significant index field.
module ptw_index_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic [IDX_W-1:0]        idx
);

    logic [IDX_W-1:0] idx_tbl [LEVELS];

    // Slice one index field per level, top field first
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_tbl[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    // Pick the field for the active level
    assign idx = idx_tbl[level];

endmodule

// File: rtl/ptw_perm_acc.sv
// Accumulates the permission flags of the entries visited so far and
// classifies the current entry's combined verdict for the pending access.
// Assumes clear comes with walk start and update with each passed level.
module ptw_perm_acc
    import ptw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       update,
    input  logic       ent_write,
    input  logic       ent_user,
    input  logic       ent_noexec,
    input  logic       is_write,
    input  logic       is_fetch,
    input  logic       is_user,
    output logic [1:0] verdict
);

    logic wr_ok_q, usr_ok_q, nx_q;
    logic wr_all, usr_all, nx_any;

    // Merge the stored flags with the entry under evaluation
    always_comb begin
        wr_all  = wr_ok_q  & ent_write;
        usr_all = usr_ok_q & ent_user;
        nx_any  = nx_q     | ent_noexec;
    end

    // Classify: user/fetch denial outranks write denial
    always_comb begin
        if ((is_user && !usr_all) || (is_fetch && nx_any))
            verdict = FLT_UXPROT;
        else if (is_write && !wr_all)
            verdict = FLT_WRPROT;
        else
            verdict = FLT_NONE;
    end

    // Hold the running flags across levels of one walk
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ok_q  <= 1'b1;
            usr_ok_q <= 1'b1;
            nx_q     <= 1'b0;
        end else if (update) begin
            wr_ok_q  <= wr_all;
            usr_ok_q <= usr_all;
            nx_q     <= nx_any;
        end
    end

    // A withdrawn write permission never returns within a walk (R7)
    assert_wr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok_q && !clear) |=> !wr_ok_q);

    // A seen no-execute flag stays seen within a walk (R8)
    assert_nx_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_q && !clear) |=> nx_q);

endmodule

// File: rtl/ptw_pte_update.sv
// Computes the entry value after marking it accessed, and dirty when asked.
// Reports whether the value differs, so unchanged entries skip writeback.
module ptw_pte_update
    import ptw_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             set_dirty,
    output logic [PTE_W-1:0] pte_out,
    output logic             changed
);

    // Raise the accessed flag, and the dirty flag for leaf writes
    always_comb begin
        pte_out = pte_in;
        pte_out[BIT_ACCESS] = 1'b1;
        if (set_dirty)
            pte_out[BIT_DIRTY] = 1'b1;
        changed = (pte_out != pte_in);
    end

endmodule

// File: rtl/pt_walker.sv
// Four-level page table walker. Reads one entry per level through a
// valid/ready request port with a separate read-return strobe, folds
// permissions across levels, writes back entries whose accessed or dirty
// flags change, and reports a physical address or fault with a done pulse.
// Assumes memory returns exactly one rvalid per accepted read and none for writes.
module pt_walker
    import ptw_pkg::*;
#(
    parameter  int LEVELS  = 4,
    parameter  int IDX_W   = 9,
    parameter  int OFF_W   = 12,
    parameter  int PA_W    = 52,
    parameter  int PTE_W   = 64,
    localparam int VA_W    = LEVELS*IDX_W + OFF_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_access,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic               mem_req_we,
    output logic [PTE_W-1:0]   mem_req_wdata,
    input  logic               mem_rvalid,
    input  logic [PTE_W-1:0]   mem_rdata,
    output logic               done,
    output logic [1:0]         fault,
    output logic [PA_W-1:0]    paddr
);

    localparam int LVL_W   = $clog2(LEVELS);
    localparam int SHIFT_W = OFF_W - IDX_W;

    walk_state_e        state_q;
    logic [LVL_W-1:0]   level_q;
    logic [VA_W-1:0]    vaddr_q;
    logic [1:0]         acc_q;
    logic               user_q;
    logic [FRAME_W-1:0] base_q;
    logic [PTE_W-1:0]   pte_q;
    logic [PTE_W-1:0]   wb_q;
    logic               done_q;
    logic [1:0]         fault_q;
    logic [PA_W-1:0]    paddr_q;

    logic [IDX_W-1:0]   cur_idx;
    logic [1:0]         verdict;
    logic [PTE_W-1:0]   pte_new;
    logic               pte_changed;
    logic               is_write, is_fetch, last_level;
    logic               start, perm_update;
    logic [PA_W-1:0]    leaf_pa;

    // Decode the latched request
    always_comb begin
        is_write   = (acc_q == ACC_WRITE);
        is_fetch   = (acc_q == ACC_FETCH);
        last_level = (level_q == LVL_W'(LEVELS-1));
        start      = req_valid && (state_q == ST_IDLE);
        leaf_pa    = {pte_q[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
    end

    ptw_index_sel #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .LVL_W  (LVL_W)
    ) u_index (
        .vpn    (vaddr_q[VA_W-1:OFF_W]),
        .level  (level_q),
        .idx    (cur_idx)
    );

    // Permission flags advance only when a level passes cleanly
    always_comb begin
        perm_update = (state_q == ST_EVAL) && pte_q[BIT_PRESENT] && (verdict == FLT_NONE);
    end

    ptw_perm_acc u_perm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .update     (perm_update),
        .ent_write  (pte_q[BIT_WRITE]),
        .ent_user   (pte_q[BIT_USER]),
        .ent_noexec (pte_q[BIT_NOEXEC]),
        .is_write   (is_write),
        .is_fetch   (is_fetch),
        .is_user    (user_q),
        .verdict    (verdict)
    );

    ptw_pte_update #(
        .PTE_W     (PTE_W)
    ) u_upd (
        .pte_in    (pte_q),
        .set_dirty (last_level && is_write),
        .pte_out   (pte_new),
        .changed   (pte_changed)
    );

    // Drive the memory port from state
    always_comb begin
        mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
        mem_req_we    = (state_q == ST_WB_REQ);
        mem_req_addr  = {base_q, cur_idx, {SHIFT_W{1'b0}}};
        mem_req_wdata = wb_q;
        req_ready     = (state_q == ST_IDLE);
        done          = done_q;
        fault         = fault_q;
        paddr         = paddr_q;
    end

    // Walk sequencer: read, evaluate, optional writeback, next level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            vaddr_q <= '0;
            acc_q   <= ACC_READ;
            user_q  <= 1'b0;
            base_q  <= '0;
            pte_q   <= '0;
            wb_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        acc_q   <= req_access;
                        user_q  <= req_user;
                        base_q  <= root_frame;
                        level_q <= '0;
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready)
                        state_q <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        pte_q   <= mem_rdata;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!pte_q[BIT_PRESENT]) begin
                        done_q  <= 1'b1;
                        fault_q <= FLT_ABSENT;
                        paddr_q <= '0;
                        state_q <= ST_IDLE;
                    end else if (verdict != FLT_NONE) begin
                        done_q  <= 1'b1;
                        fault_q <= verdict;
                        paddr_q <= '0;
                        state_q <= ST_IDLE;
                    end else if (pte_changed) begin
                        wb_q    <= pte_new;
                        state_q <= ST_WB_REQ;
                    end else if (last_level) begin
                        done_q  <= 1'b1;
                        fault_q <= FLT_NONE;
                        paddr_q <= leaf_pa;
                        state_q <= ST_IDLE;
                    end else begin
                        base_q  <= pte_q[PA_W-1:OFF_W];
                        level_q <= level_q + 1'b1;
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_WB_REQ: begin
                    if (mem_req_ready) begin
                        if (last_level) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_NONE;
                            paddr_q <= leaf_pa;
                            state_q <= ST_IDLE;
                        end else begin
                            base_q  <= pte_q[PA_W-1:OFF_W];
                            level_q <= level_q + 1'b1;
                            state_q <= ST_RD_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Stalled requests hold their fields (R10)
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata)));

    // Completion is a single-cycle pulse (R3)
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Every writeback carries the accessed and present flags (R5)
    assert_wb_accessed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[BIT_ACCESS] && mem_req_wdata[BIT_PRESENT]));

    // Non-write walks never alter the dirty flag (R6)
    assert_no_dirty_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && !is_write) |-> (mem_req_wdata[BIT_DIRTY] == pte_q[BIT_DIRTY]));

    // A successful result always carries a physical address from the leaf (R3)
    assert_ok_paddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == FLT_NONE) |-> (paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

    localparam logic [39:0] T1 = 40'h100;
    localparam logic [39:0] T2 = 40'h200;
    localparam logic [39:0] T3 = 40'h300;
    localparam logic [39:0] T4 = 40'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_access = 2'b00;
    logic        req_user = 1'b0;
    logic [39:0] root_frame = T1;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_req_we;
    logic [63:0] mem_req_wdata;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  fault;
    logic [51:0] paddr;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access), .req_user(req_user),
        .root_frame(root_frame),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
        .mem_req_wdata(mem_req_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr)
    );

    typedef struct {
        logic [51:0] addr;
        logic        we;
        logic [63:0] wdata;
        string       tag;
    } op_t;

    typedef struct {
        logic [1:0]  flt;
        logic [51:0] pa;
        string       tag;
    } res_t;

    op_t  op_q[$];
    res_t res_q[$];
    logic [63:0] mem [logic [51:0]];
    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int rd_lat = 1;
    int rd_delay = 0;
    int cyc = 0;
    logic [63:0] rd_hold = '0;
    logic done_prev = 1'b0;

    function automatic logic [63:0] mrd(input logic [51:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mkpte(input logic nx, input logic [39:0] frame,
                                          input logic [11:0] low);
        return {nx, 11'd0, frame, low};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Build a four-level chain for va with per-level low flags and no-execute bits
    task automatic mkchain(input logic [47:0] va, input logic [11:0] l1, input logic [11:0] l2,
                           input logic [11:0] l3, input logic [11:0] l4,
                           input logic [3:0] nx, input logic [39:0] leaf);
        mem[{T1, va[47:39], 3'b000}] = mkpte(nx[0], T2, l1);
        mem[{T2, va[38:30], 3'b000}] = mkpte(nx[1], T3, l2);
        mem[{T3, va[29:21], 3'b000}] = mkpte(nx[2], T4, l3);
        mem[{T4, va[20:12], 3'b000}] = mkpte(nx[3], leaf, l4);
    endtask

    // Expected memory traffic and result, from the requirements
    task automatic predict(input logic [47:0] va, input logic [1:0] acc, input logic usr,
                           input string tag);
        logic [39:0] base = T1;
        logic rw = 1'b1, us = 1'b1, nx = 1'b0;
        logic [63:0] pte = '0, npte;
        logic [51:0] a;
        for (int l = 0; l < 4; l++) begin
            a = {base, va[47-9*l -: 9], 3'b000};
            op_q.push_back('{a, 1'b0, 64'd0, tag});
            pte = mrd(a);
            if (!pte[0]) begin
                res_q.push_back('{2'b01, 52'd0, tag});
                return;
            end
            rw = rw & pte[1];
            us = us & pte[2];
            nx = nx | pte[63];
            if ((usr && !us) || (acc == 2'b10 && nx)) begin
                res_q.push_back('{2'b11, 52'd0, tag});
                return;
            end
            if (acc == 2'b01 && !rw) begin
                res_q.push_back('{2'b10, 52'd0, tag});
                return;
            end
            npte = pte | 64'h20;
            if (l == 3 && acc == 2'b01) npte = npte | 64'h40;
            if (npte != pte) op_q.push_back('{a, 1'b1, npte, tag});
            base = pte[51:12];
        end
        res_q.push_back('{2'b00, {pte[51:12], va[11:0]}, tag});
    endtask

    // Driver: predict, issue one request, wait until the scoreboard drains
    task automatic walk(input logic [47:0] va, input logic [1:0] acc, input logic usr,
                        input string tag);
        predict(va, acc, usr, tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vaddr  = va;
        req_access = acc;
        req_user   = usr;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        check(req_ready == 1'b0, "R10", "req_ready during walk", 64'(req_ready), 64'd0);
        while (res_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(op_q.size() == 0, tag, "pending memory ops", 64'(op_q.size()), 64'd0);
        op_q.delete();
    endtask

    // Memory model and memory-side monitor
    always @(negedge clk) begin
        logic rdy;
        op_t e;
        cyc++;
        mem_rvalid = 1'b0;
        if (rd_delay > 0) begin
            rd_delay--;
            if (rd_delay == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_hold;
            end
        end
        rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        mem_req_ready = rdy;
        if (rst_n && mem_req_valid && rdy) begin
            if (op_q.size() == 0) begin
                check(1'b0, "R4", "unexpected memory request", {12'd0, mem_req_addr}, 64'd0);
            end else begin
                e = op_q.pop_front();
                check(mem_req_addr == e.addr, e.tag, "request address",
                      {12'd0, mem_req_addr}, {12'd0, e.addr});
                check(mem_req_we == e.we, e.tag, "request kind",
                      64'(mem_req_we), 64'(e.we));
                if (e.we)
                    check(mem_req_wdata == e.wdata, e.tag, "writeback value",
                          mem_req_wdata, e.wdata);
            end
            if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
            else begin
                rd_hold  = mrd(mem_req_addr);
                rd_delay = rd_lat;
            end
        end
    end

    // Result monitor
    always @(negedge clk) begin
        res_t r;
        if (rst_n) begin
            if (done && done_prev)
                check(1'b0, "R3", "done longer than one cycle", 64'd1, 64'd0);
            if (done) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected done", 64'd1, 64'd0);
                end else begin
                    r = res_q.pop_front();
                    check(fault == r.flt, r.tag, "fault code", 64'(fault), 64'(r.flt));
                    check(paddr == r.pa, r.tag, "paddr", {12'd0, paddr}, {12'd0, r.pa});
                end
            end
        end
        done_prev = done;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);

        // R2/R3/R5: clean chain, user read, all flags granted
        mkchain(48'h7F12_3456_789A, 12'h007, 12'h007, 12'h007, 12'h007, 4'b0000, 40'hABCDE);
        walk(48'h7F12_3456_789A, 2'b00, 1'b1, "R2");
        // R5: second walk finds accessed flags set, no writebacks
        rdy_mode = 1; rd_lat = 3;
        walk(48'h7F12_3456_789A, 2'b00, 1'b1, "R5");
        // R6: write sets dirty only in the leaf
        walk(48'h7F12_3456_789A, 2'b01, 1'b1, "R6");
        // R6: repeated write on a dirty leaf issues no writes
        walk(48'h7F12_3456_789A, 2'b01, 1'b0, "R6");

        // R8/R9: fetch hits no-execute at level 2
        rdy_mode = 0; rd_lat = 2;
        mkchain(48'h0000_8020_1FF8, 12'h007, 12'h007, 12'h007, 12'h007, 4'b0010, 40'h12345);
        walk(48'h0000_8020_1FF8, 2'b10, 1'b0, "R8");
        // R4: absent entry at level 3, other bits set
        mkchain(48'h1234_5678_9ABC, 12'h007, 12'h007, 12'hFFE, 12'h007, 4'b0000, 40'h11111);
        walk(48'h1234_5678_9ABC, 2'b00, 1'b1, "R4");
        // R7: supervisor write, read-only at level 1
        rdy_mode = 1; rd_lat = 1;
        mkchain(48'h4444_0000_1000, 12'h005, 12'h007, 12'h007, 12'h007, 4'b0000, 40'h22222);
        walk(48'h4444_0000_1000, 2'b01, 1'b0, "R7");
        // R8: user read, supervisor-only leaf
        mkchain(48'h5555_5555_5555, 12'h007, 12'h007, 12'h007, 12'h003, 4'b0000, 40'h33333);
        walk(48'h5555_5555_5555, 2'b00, 1'b1, "R8");
        // R8: both denials at level 2, user/fetch code wins
        mkchain(48'h6666_0123_4567, 12'h007, 12'h001, 12'h007, 12'h007, 4'b0000, 40'h44444);
        walk(48'h6666_0123_4567, 2'b01, 1'b1, "R8");
        // R8: supervisor access ignores user flag
        rdy_mode = 0; rd_lat = 4;
        mkchain(48'h0777_7777_7000, 12'h003, 12'h003, 12'h003, 12'h003, 4'b0000, 40'h55555);
        walk(48'h0777_7777_7000, 2'b00, 1'b0, "R8");
        // R11: cache/size bits and upper dirty bits ignored, carried unchanged
        mkchain(48'h0888_8888_8FFF, 12'h0DF, 12'h0DF, 12'h0DF, 12'h01F, 4'b0000, 40'hFEDCB);
        walk(48'h0888_8888_8FFF, 2'b11, 1'b1, "R11");
        // R8: no-execute does not affect reads or writes
        mkchain(48'h0999_9999_9123, 12'h007, 12'h007, 12'h007, 12'h007, 4'b1111, 40'h66666);
        walk(48'h0999_9999_9123, 2'b01, 1'b1, "R8");
        // R3: fetch without no-execute succeeds
        rdy_mode = 1; rd_lat = 2;
        mkchain(48'h0AAA_0000_0ABC, 12'h007, 12'h007, 12'h007, 12'h007, 4'b0000, 40'h77777);
        walk(48'h0AAA_0000_0ABC, 2'b10, 1'b1, "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule